// File: doc/BRIEF.md
# Pin Bank Controller with Interrupt Detection

This block controls a bank of up to 32 general-purpose pins. Software reaches it through a 32-bit register port that follows APB timing. Each pin can be an input or an output. An output pin drives the value held in a register when its drive-enable bit is set. A separate per-pin select hands the pin to an alternate-function block: the drive value and drive enable then come from that block instead. The pin level is passed through a two-flop synchroniser. The synchronised level can be read back, and it is also forwarded to the alternate-function side.

Every pin feeds an interrupt detector. The detector can be set to level or edge sensitivity:
- In level mode, the pin is active-high or active-low.
- In edge mode, it reacts to a rising edge, a falling edge, or either edge.

Detected events collect in a sticky status register. Reading that register returns its contents and empties it; there is no separate acknowledge register. The interrupt mask is changed through a pair of registers that write ones to enable and ones to disable. The single interrupt output is high while any unmasked status bit is set.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the registers hold these values, and `irq` is low:
  - pin select (0x00): all ones.
  - direction (0x04): all ones.
  - interrupt mask (0x14): all ones.
  - drive enable (0x08), output value (0x0C), trigger kind (0x24), trigger sense (0x28), both-edge select (0x2C) and status (0x20): zero.
- R2: When a pin's select bit at 0x00 is 0, the pin is under register control.
  - `gpio_out` follows the output-value bit at 0x0C.
  - `gpio_oe` is high only when the direction bit at 0x04 is 0 (output) and the drive-enable bit at 0x08 is 1.
  - A pin whose direction bit is 1 (input) never drives, whatever its drive-enable bit holds.
- R3: When a pin's select bit is 1, `gpio_out` and `gpio_oe` follow `alt_out` and `alt_oe` for that pin. `alt_in` always carries the synchronised pin level, whatever the select bit holds.
- R4: Reading 0x10 returns the pin levels after the two-flop synchroniser. Writes to 0x10, 0x14 and 0x20 are ignored. Reading 0x18, 0x1C or any unmapped offset returns zero.
- R5: Writing to 0x18 clears the mask bits where the written data has a 1. Writing to 0x1C sets the mask bits where the data has a 1. Zero bits in either write leave the mask unchanged. The mask reads back at 0x14.
- R6: A trigger-kind bit of 1 selects level sensitivity for that pin. With level sensitivity:
  - a trigger-sense bit of 1 sets the status bit while the synchronised pin is high;
  - a trigger-sense bit of 0 sets the status bit while the pin is low.
- R7: A trigger-kind bit of 0 selects edge sensitivity. With edge sensitivity:
  - a trigger-sense bit of 1 sets status on a rising edge;
  - a trigger-sense bit of 0 sets status on a falling edge;
  - a both-edge bit of 1 at 0x2C makes either edge set status.
- R8: Status bits stay set until status (0x20) is read. A read returns the current bits and clears all of them in the read's setup cycle. A level condition that is still present sets its bit again immediately afterwards.
- R9: `irq` is the OR over all pins of (status AND NOT mask). Status bits are recorded whether or not the pin is masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access-phase flag |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, registered in the setup cycle |
| gpio_in | input | N_PINS | Pin levels from the pads |
| gpio_out | output | N_PINS | Value driven toward the pads |
| gpio_oe | output | N_PINS | Drive enable toward the pads |
| alt_out | input | N_PINS | Alternate-function drive value |
| alt_oe | input | N_PINS | Alternate-function drive enable |
| alt_in | output | N_PINS | Synchronised pin level for the alternate function |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that register transfers follow the two-phase sequence: a setup cycle with `penable` low, then one access cycle. Under that assumption, a read of status clears it exactly once, and a mask write updates the mask exactly once. The bench drives every transfer through a single pair of tasks that produce this sequence and nothing else. Pin inputs are changed on the falling clock edge only, and they are held for several cycles, so each level or edge passes cleanly through the synchroniser before status is read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [7:0] OFS_SELECT  = 8'h00;
  localparam logic [7:0] OFS_DIR     = 8'h04;
  localparam logic [7:0] OFS_DRIVE   = 8'h08;
  localparam logic [7:0] OFS_OUTVAL  = 8'h0C;
  localparam logic [7:0] OFS_LEVELS  = 8'h10;
  localparam logic [7:0] OFS_MASK    = 8'h14;
  localparam logic [7:0] OFS_UNMASK  = 8'h18;
  localparam logic [7:0] OFS_SETMASK = 8'h1C;
  localparam logic [7:0] OFS_STATUS  = 8'h20;
  localparam logic [7:0] OFS_KIND    = 8'h24;
  localparam logic [7:0] OFS_SENSE   = 8'h28;
  localparam logic [7:0] OFS_BOTH    = 8'h2C;

  typedef enum logic [1:0] {ACC_IDLE, ACC_RD_SETUP, ACC_WR_ACCESS} acc_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic         clr,
  output logic [W-1:0] status
);
  logic [W-1:0] lvl_d;
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = lvl[i] & ~lvl_d[i];
    assign fall     = ~lvl[i] & lvl_d[i];
    assign edge_hit = both[i] ? (rise | fall) : (sense[i] ? rise : fall);
    assign lvl_hit  = sense[i] ? lvl[i] : ~lvl[i];
    assign hit[i]   = kind[i] ? lvl_hit : edge_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d  <= '0;
      status <= '0;
    end else begin
      lvl_d  <= lvl;
      status <= clr ? hit : (status | hit);
    end
  end

  // R8: bits only drop on a clearing read
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (($past(status) & ~status) == '0));
  // R8: a clearing read with no fresh event leaves status empty
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && (hit == '0)) |=> (status == '0));
  // R6: a new status bit always comes from a detected condition
  assert_set_source_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((status & ~$past(status)) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      status,
  output logic              clr,
  output logic [W-1:0]      sel,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      drive,
  output logic [W-1:0]      outval,
  output logic [W-1:0]      kind,
  output logic [W-1:0]      sense,
  output logic [W-1:0]      both,
  output logic [W-1:0]      mask
);
  localparam logic [ADDR_W-1:0] A_SELECT  = ADDR_W'(OFS_SELECT);
  localparam logic [ADDR_W-1:0] A_DIR     = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_DRIVE   = ADDR_W'(OFS_DRIVE);
  localparam logic [ADDR_W-1:0] A_OUTVAL  = ADDR_W'(OFS_OUTVAL);
  localparam logic [ADDR_W-1:0] A_LEVELS  = ADDR_W'(OFS_LEVELS);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_UNMASK  = ADDR_W'(OFS_UNMASK);
  localparam logic [ADDR_W-1:0] A_SETMASK = ADDR_W'(OFS_SETMASK);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_KIND    = ADDR_W'(OFS_KIND);
  localparam logic [ADDR_W-1:0] A_SENSE   = ADDR_W'(OFS_SENSE);
  localparam logic [ADDR_W-1:0] A_BOTH    = ADDR_W'(OFS_BOTH);

  acc_e          acc;
  logic [W-1:0]  wd;
  logic [W-1:0]  rd_sel;
  logic [31:0]   rd_word;
  logic          unused_bits;

  assign wd          = pwdata[W-1:0];
  assign unused_bits = ^pwdata;

  always_comb begin
    if (psel && penable && pwrite)        acc = ACC_WR_ACCESS;
    else if (psel && !penable && !pwrite) acc = ACC_RD_SETUP;
    else                                  acc = ACC_IDLE;
  end

  assign clr = (acc == ACC_RD_SETUP) && (paddr == A_STATUS);

  always_comb begin
    case (paddr)
      A_SELECT: rd_sel = sel;
      A_DIR:    rd_sel = dir;
      A_DRIVE:  rd_sel = drive;
      A_OUTVAL: rd_sel = outval;
      A_LEVELS: rd_sel = lvl;
      A_MASK:   rd_sel = mask;
      A_STATUS: rd_sel = status;
      A_KIND:   rd_sel = kind;
      A_SENSE:  rd_sel = sense;
      A_BOTH:   rd_sel = both;
      default:  rd_sel = '0;
    endcase
    rd_word         = '0;
    rd_word[W-1:0]  = rd_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= '1;
      dir    <= '1;
      drive  <= '0;
      outval <= '0;
      kind   <= '0;
      sense  <= '0;
      both   <= '0;
      mask   <= '1;
      prdata <= '0;
    end else begin
      if (acc == ACC_RD_SETUP) prdata <= rd_word;
      if (acc == ACC_WR_ACCESS) begin
        case (paddr)
          A_SELECT:  sel    <= wd;
          A_DIR:     dir    <= wd;
          A_DRIVE:   drive  <= wd;
          A_OUTVAL:  outval <= wd;
          A_UNMASK:  mask   <= mask & ~wd;
          A_SETMASK: mask   <= mask | wd;
          A_KIND:    kind   <= wd;
          A_SENSE:   sense  <= wd;
          A_BOTH:    both   <= wd;
          default:   ;
        endcase
      end
    end
  end

  // R5: an unmask write clears exactly the written-one bits
  assert_unmask_R5: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_WR_ACCESS && paddr == A_UNMASK) |=> (mask == ($past(mask) & ~$past(wd))));
  // R5: a set-mask write raises exactly the written-one bits
  assert_setmask_R5: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_WR_ACCESS && paddr == A_SETMASK) |=> (mask == ($past(mask) | $past(wd))));
  // R4: a write to the mask offset itself leaves the mask alone
  assert_mask_ro_R4: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_WR_ACCESS && paddr == A_MASK) |=> $stable(mask));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [N_PINS-1:0] gpio_in,
  output logic [N_PINS-1:0] gpio_out,
  output logic [N_PINS-1:0] gpio_oe,
  input  logic [N_PINS-1:0] alt_out,
  input  logic [N_PINS-1:0] alt_oe,
  output logic [N_PINS-1:0] alt_in,
  output logic              irq
);
  logic [N_PINS-1:0] lvl, status, sel, dir, drive, outval, kind, sense, both, mask;
  logic              clr;

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(gpio_in), .q(lvl)
  );

  gpio_regs #(.W(N_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .lvl(lvl),
    .status(status), .clr(clr), .sel(sel), .dir(dir), .drive(drive),
    .outval(outval), .kind(kind), .sense(sense), .both(both), .mask(mask)
  );

  gpio_irq_detect #(.W(N_PINS)) u_detect (
    .clk(clk), .rst(rst), .lvl(lvl), .kind(kind), .sense(sense),
    .both(both), .clr(clr), .status(status)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_mux
    assign gpio_out[i] = sel[i] ? alt_out[i] : outval[i];
    assign gpio_oe[i]  = sel[i] ? alt_oe[i]  : (~dir[i] & drive[i]);
  end

  assign alt_in = lvl;
  assign irq    = |(status & ~mask);

  // R2: a register-controlled input pin never drives
  assert_input_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ((~sel & dir & gpio_oe) == '0));
  // R9: fully masked bank keeps the interrupt low
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (&mask) |-> !irq);
  // R9: interrupt needs some recorded status
  assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status != '0));
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  localparam int N  = 8;
  localparam int AW = 8;
  localparam logic [31:0] ALL = (32'd1 << N) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [N-1:0] gpio_in = '0, gpio_out, gpio_oe, alt_out = '0, alt_oe = '0, alt_in;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.N_PINS(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .alt_out(alt_out),
    .alt_oe(alt_oe), .alt_in(alt_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; d = prdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] a_dir, a_drv, a_val, a_sel, a_ao, a_aoe;
    repeat (4) @(negedge clk);
    rst = 0;
    idle(2);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(8'h00, r); chk("R1 select", r, ALL);
    rd(8'h04, r); chk("R1 dir", r, ALL);
    rd(8'h14, r); chk("R1 mask", r, ALL);
    rd(8'h08, r); chk("R1 drive", r, 0);
    rd(8'h0C, r); chk("R1 outval", r, 0);
    rd(8'h24, r); chk("R1 kind", r, 0);
    rd(8'h28, r); chk("R1 sense", r, 0);
    rd(8'h2C, r); chk("R1 both", r, 0);
    rd(8'h20, r); chk("R1 status", r, 0);

    // R2 register-controlled pins
    wr(8'h00, 0);
    for (int k = 0; k < 16; k++) begin
      a_dir = 8'(k * 37 + 5); a_drv = 8'(k * 91 + 3); a_val = 8'(k * 53 + 11);
      wr(8'h04, {24'd0, a_dir}); wr(8'h08, {24'd0, a_drv}); wr(8'h0C, {24'd0, a_val});
      chk("R2 oe", {24'd0, gpio_oe}, {24'd0, ~a_dir & a_drv});
      chk("R2 out", {24'd0, gpio_out}, {24'd0, a_val});
    end

    // R3 alternate-function pins
    for (int k = 0; k < 16; k++) begin
      a_sel = 8'(k * 29 + 1); a_ao = 8'(k * 77 + 9); a_aoe = 8'(k * 13 + 200);
      gpio_in = 8'(k * 45 + 7);
      wr(8'h00, {24'd0, a_sel});
      alt_out = a_ao; alt_oe = a_aoe;
      idle(1);
      chk("R3 out", {24'd0, gpio_out}, {24'd0, (a_sel & a_ao) | (~a_sel & a_val)});
      chk("R3 oe", {24'd0, gpio_oe}, {24'd0, (a_sel & a_aoe) | (~a_sel & ~a_dir & a_drv)});
      chk("R3 alt_in", {24'd0, alt_in}, {24'd0, gpio_in});
      rd(8'h10, r); chk("R4 levels", r, {24'd0, gpio_in});
    end
    wr(8'h00, ALL);

    // R4 read-only and zero-reading offsets
    gpio_in = 8'h3C; idle(4);
    wr(8'h10, 32'hFF); rd(8'h10, r); chk("R4 levels ro", r, 32'h3C);
    wr(8'h14, 32'h00); rd(8'h14, r); chk("R4 mask ro", r, ALL);
    rd(8'h18, r); chk("R4 unmask reads 0", r, 0);
    rd(8'h1C, r); chk("R4 setmask reads 0", r, 0);
    rd(8'h30, r); chk("R4 unmapped", r, 0);
    gpio_in = 0; idle(4);
    rd(8'h20, r);
    wr(8'h20, 32'hFF); rd(8'h20, r); chk("R4 status ro", r, 0);

    // R5 mask pair
    wr(8'h18, 32'h0F); rd(8'h14, r); chk("R5 unmask", r, 32'hF0);
    wr(8'h18, 32'h00); rd(8'h14, r); chk("R5 zero unmask", r, 32'hF0);
    wr(8'h1C, 32'h03); rd(8'h14, r); chk("R5 setmask", r, 32'hF3);
    wr(8'h1C, 32'h00); rd(8'h14, r); chk("R5 zero setmask", r, 32'hF3);
    wr(8'h18, ALL);    rd(8'h14, r); chk("R5 unmask all", r, 0);

    // R6 R7 R8 sweep: modes x pins x start level
    for (int m = 0; m < 5; m++) begin
      logic kd, sn, bo;
      kd = (m < 2); sn = (m == 0) || (m == 2); bo = (m == 4);
      wr(8'h24, kd ? ALL : 0); wr(8'h28, sn ? ALL : 0); wr(8'h2C, bo ? ALL : 0);
      for (int i = 0; i < N; i++) begin
        for (int l0 = 0; l0 < 2; l0++) begin
          logic [7:0] base, ex;
          logic l1, hit;
          base = (kd && sn) ? 8'h00 : (kd ? 8'hFF : 8'h00);
          gpio_in = base; gpio_in[i] = l0[0];
          idle(6);
          rd(8'h20, r);
          rd(8'h20, r);
          ex = (kd && (l0[0] == sn)) ? (8'd1 << i) : 8'd0;
          chk(kd ? "R8 level re-set" : "R8 cleared", r, {24'd0, ex});
          l1 = ~l0[0];
          gpio_in[i] = l1;
          idle(6);
          if (kd) hit = (l0[0] == sn) || (l1 == sn);
          else    hit = bo || (sn ? l1 : !l1);
          ex = hit ? (8'd1 << i) : 8'd0;
          chk("R9 irq", {31'd0, irq}, {31'd0, hit});
          rd(8'h20, r);
          chk(kd ? "R6 level" : "R7 edge", r, {24'd0, ex});
        end
      end
    end

    // R9 masked pins still record status
    wr(8'h24, 0); wr(8'h28, ALL); wr(8'h2C, 0);
    gpio_in = 0; idle(6); rd(8'h20, r);
    wr(8'h1C, 32'h01);
    gpio_in = 8'h01; idle(6);
    chk("R9 masked irq", {31'd0, irq}, 0);
    gpio_in = 8'h03; idle(6);
    chk("R9 unmasked irq", {31'd0, irq}, 1);
    rd(8'h20, r); chk("R9 status", r, 32'h03);
    idle(2);
    chk("R8 irq after clear", {31'd0, irq}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule